// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block turns an unrounded single-precision result into its final packed 32-bit word. An upstream arithmetic unit hands over the sign, the biased exponent and a 24-bit significand that has already been normalized so that its top bit is one. It also supplies three extra bits from below the fraction LSB, called guard, round and sticky. A 2-bit mode input selects one of four rounding rules. The block decides whether to add one unit in the last place. If that addition carries out of the significand, it shifts the significand right and bumps the exponent.

When the rounded exponent reaches the all-ones code, the block saturates. The result is either infinity or the largest finite magnitude, depending on the mode and the sign, and an overflow flag is raised. A separate inexact flag reports that any discarded bit was set. The datapath is purely combinational. A parameter adds one output register, and the default build has it, so results appear one clock after their inputs. There is no state machine. The only storage is that optional output stage, which has two states, reset (all zero) and loaded.

Top module: `fpr_round_unit`

## Requirements
- R1: The output word carries the sign in bit 31, the 8-bit biased exponent in bits 30:23 and the 23-bit fraction in bits 22:0. The significand's leading one is not stored, and an exact input (guard, round and sticky all zero) with an exponent of 1..254 passes through unchanged.
- R2: Mode code 00 rounds to nearest with ties to even. One is added when guard is 1 and at least one of round, sticky or the fraction LSB is 1.
- R3: Mode code 01 rounds toward zero. The fraction and exponent are never incremented.
- R4: Mode code 10 rounds toward +infinity and adds one when any of guard, round or sticky is set on a positive value (sign 0). Mode code 11 rounds toward -infinity and adds one under the same condition on a negative value (sign 1). Neither mode increments a value of the other sign.
- R5: When the increment carries out of the 24-bit significand, the stored fraction becomes all zeros and the exponent rises by one.
- R6: When the rounded exponent is 255 or more, the overflow flag is 1. The word becomes infinity (exponent 255, fraction 0) in mode 00, in mode 10 for sign 0 and in mode 11 for sign 1. Otherwise it becomes the largest finite value (exponent 254, fraction all ones). The sign is kept in both cases. The flag is 0 in every other case.
- R7: The inexact flag equals the OR of guard, round and sticky.
- R8: With the output register enabled (the default), word, overflow and inexact update on the clock edge after the inputs. An active-low reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| sign_i | input | 1 | Sign of the unrounded value |
| exp_i | input | 8 | Biased exponent (bias 127), expected 1..254 |
| sig_i | input | 24 | Normalized significand, bit 23 is the leading one |
| guard_i | input | 1 | First discarded bit below the fraction LSB |
| round_i | input | 1 | Second discarded bit |
| sticky_i | input | 1 | OR of all lower discarded bits |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 zero, 10 +inf, 11 -inf |
| word_o | output | 32 | Rounded packed word |
| ovf_o | output | 1 | Overflow after rounding |
| inexact_o | output | 1 | Some discarded bit was nonzero |

## Verification
A wrong increment decision shows up as a fraction one unit off in the last place. It appears on the port one clock after the offending input, and only for input patterns where the mode, sign and guard/round/sticky bits make that decision matter, so ties and sign-dependent directed cases are driven explicitly. A broken carry path leaves a zero fraction paired with the old exponent, or a wrapped exponent. A wrong saturation choice swaps infinity for the largest finite value. Each of these is visible in the same cycle as the corresponding flag.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;
endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
    import fpr_pkg::*;
(
    input  logic   sign_i,
    input  logic   lsb_i,
    input  logic   guard_i,
    input  logic   round_i,
    input  logic   sticky_i,
    input  rmode_e mode_i,
    output logic   inc_o,
    output logic   lost_o
);
    logic below_half;

    always_comb begin
        below_half = round_i | sticky_i;
        lost_o     = guard_i | below_half;
        unique case (mode_i)
            RM_NEAR: inc_o = guard_i & (below_half | lsb_i);
            RM_ZERO: inc_o = 1'b0;
            RM_UP:   inc_o = lost_o & ~sign_i;
            RM_DOWN: inc_o = lost_o & sign_i;
            default: inc_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W:0]   sig_i,
    input  logic              inc_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic              carry_o
);
    localparam int SUM_W = FRAC_W + 2;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = {1'b0, sig_i} + {{(SUM_W-1){1'b0}}, inc_i};
        carry_o = sum[SUM_W-1];
        if (carry_o) frac_o = sum[FRAC_W:1];
        else         frac_o = sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
    import fpr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      sign_i,
    input  logic [EXP_W-1:0]          exp_i,
    input  logic                      carry_i,
    input  logic [FRAC_W-1:0]         frac_i,
    input  rmode_e                    mode_i,
    output logic [EXP_W+FRAC_W:0]     word_o,
    output logic                      ovf_o
);
    localparam logic [EXP_W:0]   EXP_TOP = {1'b0, {EXP_W{1'b1}}};
    localparam logic [EXP_W-1:0] EXP_MAX = {{(EXP_W-1){1'b1}}, 1'b0};

    logic [EXP_W:0] exp_sum;
    logic           to_inf;

    always_comb begin
        exp_sum = {1'b0, exp_i} + {{EXP_W{1'b0}}, carry_i};
        ovf_o   = (exp_sum >= EXP_TOP);
        unique case (mode_i)
            RM_NEAR: to_inf = 1'b1;
            RM_ZERO: to_inf = 1'b0;
            RM_UP:   to_inf = ~sign_i;
            RM_DOWN: to_inf = sign_i;
            default: to_inf = 1'b0;
        endcase
        if (!ovf_o)
            word_o = {sign_i, exp_sum[EXP_W-1:0], frac_i};
        else if (to_inf)
            word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            word_o = {sign_i, EXP_MAX, {FRAC_W{1'b1}}};
    end
endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
    import fpr_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sign_i,
    input  logic [EXP_W-1:0]      exp_i,
    input  logic [FRAC_W:0]       sig_i,
    input  logic                  guard_i,
    input  logic                  round_i,
    input  logic                  sticky_i,
    input  logic [1:0]            mode_i,
    output logic [EXP_W+FRAC_W:0] word_o,
    output logic                  ovf_o,
    output logic                  inexact_o
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;

    rmode_e              mode;
    logic                inc;
    logic                lost;
    logic [FRAC_W-1:0]   frac_r;
    logic                carry;
    logic [WORD_W-1:0]   word_c;
    logic                ovf_c;

    assign mode = rmode_e'(mode_i);

    fpr_decide u_decide (
        .sign_i  (sign_i),
        .lsb_i   (sig_i[0]),
        .guard_i (guard_i),
        .round_i (round_i),
        .sticky_i(sticky_i),
        .mode_i  (mode),
        .inc_o   (inc),
        .lost_o  (lost)
    );

    fpr_incr #(.FRAC_W(FRAC_W)) u_incr (
        .sig_i  (sig_i),
        .inc_i  (inc),
        .frac_o (frac_r),
        .carry_o(carry)
    );

    fpr_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .sign_i (sign_i),
        .exp_i  (exp_i),
        .carry_i(carry),
        .frac_i (frac_r),
        .mode_i (mode),
        .word_o (word_c),
        .ovf_o  (ovf_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_o    <= '0;
                    ovf_o     <= 1'b0;
                    inexact_o <= 1'b0;
                end else begin
                    word_o    <= word_c;
                    ovf_o     <= ovf_c;
                    inexact_o <= lost;
                end
            end

            // R1: exact in-range values pass through the stage untouched
            a_r1_exact_pass: assert property (@(posedge clk) disable iff (!rst_n)
                (!guard_i && !round_i && !sticky_i && exp_i != {EXP_W{1'b1}})
                |=> word_o == $past({sign_i, exp_i, sig_i[FRAC_W-1:0]}));

            // R3: truncation keeps exponent and fraction
            a_r3_no_increment: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == RM_ZERO && exp_i != {EXP_W{1'b1}})
                |=> word_o[WORD_W-2:0] == $past({exp_i, sig_i[FRAC_W-1:0]}));

            // R6: a saturated word is infinity or the largest finite value
            a_r6_sat_shape: assert property (@(posedge clk) disable iff (!rst_n)
                ovf_o |-> ((word_o[WORD_W-2:FRAC_W] == {EXP_W{1'b1}} && word_o[FRAC_W-1:0] == '0)
                        || (word_o[WORD_W-2:FRAC_W] == {{(EXP_W-1){1'b1}}, 1'b0}
                            && word_o[FRAC_W-1:0] == {FRAC_W{1'b1}})));

            // R7: inexact follows the discarded bits one clock later
            a_r7_inexact: assert property (@(posedge clk) disable iff (!rst_n)
                (guard_i || round_i || sticky_i) |=> inexact_o);

            // R8: sign always travels through the register stage
            a_r8_sign_delay: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> word_o[WORD_W-1] == $past(sign_i));
        end else begin : g_comb
            assign word_o    = word_c;
            assign ovf_o     = ovf_c;
            assign inexact_o = lost;
        end
    endgenerate
endmodule

// File: tb/fpr_round_unit_test.sv
module fpr_round_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sign_i = 1'b0;
    logic [7:0]  exp_i = '0;
    logic [23:0] sig_i = '0;
    logic        guard_i = 1'b0, round_i = 1'b0, sticky_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [31:0] word_o;
    logic        ovf_o, inexact_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fpr_round_unit uut (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
        .guard_i(guard_i), .round_i(round_i), .sticky_i(sticky_i), .mode_i(mode_i),
        .word_o(word_o), .ovf_o(ovf_o), .inexact_o(inexact_o)
    );

    // Reference model: returns {ovf, inexact, word}
    function automatic logic [33:0] model(input logic s, input logic [7:0] e,
            input logic [23:0] m, input logic g, input logic r, input logic k,
            input logic [1:0] md);
        logic up;
        logic any;
        int   mag;
        int   ex;
        any = g | r | k;
        case (md)
            2'b00: up = g && (r || k || m[0]);
            2'b01: up = 0;
            2'b10: up = any && (s == 0);
            default: up = any && (s == 1);
        endcase
        mag = int'(m) + (up ? 1 : 0);
        ex  = int'(e);
        if (mag >= 32'h0100_0000) begin
            mag = mag / 2;
            ex  = ex + 1;
        end
        if (ex >= 255) begin
            if (md == 2'b00 || (md == 2'b10 && !s) || (md == 2'b11 && s))
                return {1'b1, any, s, 8'hFF, 23'h0};
            return {1'b1, any, s, 8'hFE, 23'h7FFFFF};
        end
        return {1'b0, any, s, ex[7:0], mag[22:0]};
    endfunction

    function automatic string tag_of(input logic [33:0] exp_v, input logic [7:0] e,
            input logic [1:0] md);
        if (exp_v[33]) return "R6";
        if (exp_v[30:23] != e) return "R5";
        case (md)
            2'b00: return "R2";
            2'b01: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic apply(input logic s, input logic [7:0] e, input logic [23:0] m,
            input logic g, input logic r, input logic k, input logic [1:0] md);
        logic [33:0] exp_v;
        string t;
        @(negedge clk);
        sign_i = s; exp_i = e; sig_i = m;
        guard_i = g; round_i = r; sticky_i = k; mode_i = md;
        exp_v = model(s, e, m, g, r, k, md);
        t = tag_of(exp_v, e, md);
        @(negedge clk);
        checks++;
        if (word_o != exp_v[31:0] || ovf_o != exp_v[33]) begin
            errors++;
            $display("FAIL %s word/ovf: got %h/%b expected %h/%b (s=%b e=%h m=%h grs=%b%b%b md=%b)",
                t, word_o, ovf_o, exp_v[31:0], exp_v[33], s, e, m, g, r, k, md);
        end
        checks++;
        if (inexact_o != exp_v[32]) begin
            errors++;
            $display("FAIL R7 inexact: got %b expected %b", inexact_o, exp_v[32]);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (word_o != 32'h0 || ovf_o || inexact_o) begin
            errors++;
            $display("FAIL R8 reset: got %h %b %b expected 0 0 0", word_o, ovf_o, inexact_o);
        end
        rst_n = 1'b1;

        // R1: exact passthrough
        apply(1'b0, 8'h7F, 24'hC00000, 0, 0, 0, 2'b00);
        apply(1'b1, 8'h01, 24'h800001, 0, 0, 0, 2'b10);
        // R2: ties to even, above and below half
        apply(1'b0, 8'h80, 24'h800000, 1, 0, 0, 2'b00);
        apply(1'b0, 8'h80, 24'h800001, 1, 0, 0, 2'b00);
        apply(1'b0, 8'h80, 24'h800000, 1, 0, 1, 2'b00);
        apply(1'b0, 8'h80, 24'h800001, 0, 1, 1, 2'b00);
        // R3: truncation with all bits set
        apply(1'b1, 8'h90, 24'hFFFFFF, 1, 1, 1, 2'b01);
        // R4: sign dependency of directed modes
        apply(1'b0, 8'h90, 24'h812345, 0, 0, 1, 2'b10);
        apply(1'b1, 8'h90, 24'h812345, 0, 0, 1, 2'b10);
        apply(1'b1, 8'h90, 24'h812345, 0, 1, 0, 2'b11);
        apply(1'b0, 8'h90, 24'h812345, 0, 1, 0, 2'b11);
        // R5: carry-out renormalization
        apply(1'b0, 8'h85, 24'hFFFFFF, 1, 0, 0, 2'b00);
        apply(1'b1, 8'h20, 24'hFFFFFF, 0, 0, 1, 2'b11);
        // R6: overflow in every mode and sign
        for (int md = 0; md < 4; md++) begin
            apply(1'b0, 8'hFE, 24'hFFFFFF, 1, 1, 1, md[1:0]);
            apply(1'b1, 8'hFE, 24'hFFFFFF, 1, 1, 1, md[1:0]);
        end
        apply(1'b0, 8'hFE, 24'hFFFFFF, 0, 0, 0, 2'b00);

        // R8: output holds until the next edge
        @(negedge clk);
        sign_i = 1'b1; exp_i = 8'h40; sig_i = 24'h900000;
        guard_i = 0; round_i = 0; sticky_i = 0; mode_i = 2'b01;
        #1;
        checks++;
        if (word_o != 32'h7F7FFFFF) begin
            errors++;
            $display("FAIL R8 latency: got %h expected 7f7fffff", word_o);
        end
        @(negedge clk);
        checks++;
        if (word_o != 32'hA0100000) begin
            errors++;
            $display("FAIL R8 update: got %h expected a0100000", word_o);
        end

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  e;
            logic [23:0] m;
            logic [2:0]  grs;
            e = 8'(1 + ($urandom % 254));
            if (($urandom % 8) == 0) e = 8'hFE;
            m = {1'b1, 23'($urandom)};
            if (($urandom % 8) == 0) m = 24'hFFFFFF;
            grs = 3'($urandom);
            apply(1'($urandom), e, m, grs[2], grs[1], grs[0], 2'($urandom));
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule